// File: doc/BRIEF.md
# PMIC Mission Power-State Controller

This block is the mission-mode sequencer of a power-management controller. It leaves reset (or a return from the fixed hardware recovery machine) in an initialization phase. That phase switches off the residual-voltage checks, marks the first start-up as done and unmasks the supply over- and under-voltage monitors. After that the block waits in standby. A valid ON request or an MCU-only request, given while the supply is above its under-voltage threshold, moves it into one of the five mission states: standby, active, MCU-only, SoC power error or retention.

Each state has a target set of four rail groups: the MCU safety island, the main processor domain, the GPIO-retention rails and the DDR-retention rails. A small sequencer moves the live rail enables toward that target one group at a time and waits a programmable number of cycles after each change. It raises a done flag once nothing is pending. A hard fault, or a loss of supply, sends the block into a shutdown phase that is reported as standby. In that phase every rail group goes off. The block then hands control to the hardware recovery machine and waits for an acknowledge before it initializes again.

Top module: `pwr_state_ctrl`

## Requirements
- R1: In reset `vsup_mask` is 2'b11 and the other init flags are 0. On the four clock edges after reset (or after `hw_ack` in the handoff phase), the block sets `buck_rv_off`, then `ldo_rv_off`, then `first_boot_done`, and then clears `vsup_mask` to 0 while raising `init_done`. `hw_ack` returns `buck_rv_off`, `ldo_rv_off`, `init_done` to 0 and `vsup_mask` to 2'b11.
- R2: The block leaves standby only after initialization is complete and only while `supply_ok` is high. An `on_req` given during initialization, or while `supply_ok` is low, leaves `mode` at standby.
- R3: In standby (`mode` = 0) all rail enables are low and `drv_out` is low.
- R4: In active (`mode` = 1) all four rail groups end up enabled and `drv_bit` is set.
- R5: In MCU-only (`mode` = 2) and in SoC power error (`mode` = 3), only the MCU island group ends up enabled.
- R6: In SoC power error, only `soc_clear` is honoured, and it moves the block to MCU-only. `on_req`, `go_mcu`, `go_ret` and `soc_fault` have no effect there.
- R7: Entering retention (`mode` = 4) clears `drv_bit`. `ret_cfg[5]` keeps the GPIO-retention group on and `ret_cfg[7]` keeps the DDR-retention group on. Both bits are taken only in the cycle in which the retention request is accepted; later changes are ignored.
- R8: A `hard_fault` in standby or in any mission state, or a low `supply_ok` in a non-standby mission state, sends the block to a shutdown phase reported as `mode` = 0. In that phase all groups switch off, then `hw_handoff` rises and stays high until `hw_ack`.
- R9: Rail groups change one at a time. After each change the sequencer waits `step_gap` cycles before the next one. Groups switch on in the order MCU, main, GPIO, DDR, and switch off in the reverse order. `seq_done` is high when no change is pending and the wait has run out.
- R10: When several requests arrive in the same cycle, the priority is: hard fault or supply loss, then `soc_fault`, then `go_ret`, then `go_mcu`, then `on_req`.
- R11: `mode` encodes standby 0, active 1, MCU-only 2, SoC power error 3, retention 4. The initialization, shutdown and handoff phases report 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its under-voltage threshold |
| on_req | input | 1 | ON request, targets active |
| go_mcu | input | 1 | Request for MCU-only |
| go_ret | input | 1 | Request for retention |
| soc_fault | input | 1 | SoC power error request |
| soc_clear | input | 1 | The single exit from SoC power error |
| hard_fault | input | 1 | Error that forces shutdown and handoff |
| ret_cfg | input | 8 | Retention select bits (bit 5 GPIO, bit 7 DDR) |
| step_gap | input | DLY_W | Wait cycles after each rail-group change |
| hw_ack | input | 1 | Recovery machine returns control |
| mcu_en | output | MCU_RAILS | MCU island rail enables |
| main_en | output | MAIN_RAILS | Main domain rail enables |
| gpio_en | output | GPIO_RAILS | GPIO-retention rail enables |
| ddr_en | output | DDR_RAILS | DDR-retention rail enables |
| drv_out | output | 1 | External driver-enable pin |
| drv_bit | output | 1 | Driver-enable control bit |
| mode | output | 3 | Mission state code |
| init_done | output | 1 | Initialization finished |
| seq_done | output | 1 | Rail sequencing finished |
| hw_handoff | output | 1 | Control handed to recovery machine |
| buck_rv_off | output | 1 | Buck residual-voltage checks disabled |
| ldo_rv_off | output | 1 | LDO residual-voltage checks disabled |
| first_boot_done | output | 1 | First start-up completed flag |
| vsup_mask | output | 2 | Supply OV/UV mask bits |

## Verification
A wrong state register shows at `mode` on the next edge. The rail enables show it only later: the first group differs one edge after the wrong state, and the later groups only after each `step_gap` wait. A bad latch of the retention select bits is therefore visible only after the sequencer has settled. A wrong phase in the shutdown path shows as `hw_handoff` rising too early, or never, while groups are still on. A fault in the initialization counter shows within four edges as an init flag set out of order.

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl #(
  parameter int MCU_RAILS  = 3,
  parameter int MAIN_RAILS = 5,
  parameter int GPIO_RAILS = 2,
  parameter int DDR_RAILS  = 2,
  parameter int DLY_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  supply_ok,
  input  logic                  on_req,
  input  logic                  go_mcu,
  input  logic                  go_ret,
  input  logic                  soc_fault,
  input  logic                  soc_clear,
  input  logic                  hard_fault,
  input  logic [7:0]            ret_cfg,
  input  logic [DLY_W-1:0]      step_gap,
  input  logic                  hw_ack,
  output logic [MCU_RAILS-1:0]  mcu_en,
  output logic [MAIN_RAILS-1:0] main_en,
  output logic [GPIO_RAILS-1:0] gpio_en,
  output logic [DDR_RAILS-1:0]  ddr_en,
  output logic                  drv_out,
  output logic                  drv_bit,
  output logic [2:0]            mode,
  output logic                  init_done,
  output logic                  seq_done,
  output logic                  hw_handoff,
  output logic                  buck_rv_off,
  output logic                  ldo_rv_off,
  output logic                  first_boot_done,
  output logic [1:0]            vsup_mask
);

  localparam int NGRP = 4;

  typedef enum logic [2:0] {
    P_INIT, P_STBY, P_ACT, P_MCU, P_SERR, P_RET, P_DOWN, P_HAND
  } ph_t;

  ph_t ph, nxt;
  logic [1:0]      istep;
  logic [NGRP-1:0] grp, tgt, off_m, on_m;
  logic [1:0]      hi_i, lo_i;
  logic [DLY_W-1:0] cnt;
  logic            ret_g, ret_d;
  logic            lost;

  assign lost = hard_fault | ~supply_ok;

  always_comb begin
    nxt = ph;
    unique case (ph)
      P_INIT: if (istep == 2'd3) nxt = P_STBY;
      P_STBY: begin
        if (hard_fault) nxt = P_DOWN;
        else if (supply_ok) begin
          if (go_mcu) nxt = P_MCU;
          else if (on_req) nxt = P_ACT;
        end
      end
      P_ACT, P_MCU, P_RET: begin
        if (lost) nxt = P_DOWN;
        else if (soc_fault && ph != P_RET) nxt = P_SERR;
        else if (go_ret && ph != P_RET) nxt = P_RET;
        else if (go_mcu) nxt = P_MCU;
        else if (on_req) nxt = P_ACT;
      end
      P_SERR: begin
        if (lost) nxt = P_DOWN;
        else if (soc_clear) nxt = P_MCU;
      end
      P_DOWN: if (grp == '0 && cnt == '0) nxt = P_HAND;
      P_HAND: if (hw_ack) nxt = P_INIT;
      default: nxt = P_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= P_INIT;
      ret_g   <= 1'b0;
      ret_d   <= 1'b0;
      drv_bit <= 1'b0;
    end else begin
      ph <= nxt;
      if (nxt == P_RET && ph != P_RET) begin
        ret_g <= ret_cfg[5];
        ret_d <= ret_cfg[7];
      end
      if (nxt == P_ACT) drv_bit <= 1'b1;
      else if (nxt != P_MCU && nxt != P_SERR) drv_bit <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      istep           <= 2'd0;
      buck_rv_off     <= 1'b0;
      ldo_rv_off      <= 1'b0;
      first_boot_done <= 1'b0;
      vsup_mask       <= 2'b11;
      init_done       <= 1'b0;
    end else if (ph == P_INIT) begin
      istep <= istep + 2'd1;
      case (istep)
        2'd0: buck_rv_off     <= 1'b1;
        2'd1: ldo_rv_off      <= 1'b1;
        2'd2: first_boot_done <= 1'b1;
        default: begin
          vsup_mask <= 2'b00;
          init_done <= 1'b1;
        end
      endcase
    end else if (ph == P_HAND && hw_ack) begin
      istep       <= 2'd0;
      buck_rv_off <= 1'b0;
      ldo_rv_off  <= 1'b0;
      vsup_mask   <= 2'b11;
      init_done   <= 1'b0;
    end
  end

  always_comb begin
    unique case (ph)
      P_ACT:         tgt = 4'b1111;
      P_MCU, P_SERR: tgt = 4'b0001;
      P_RET:         tgt = {ret_d, ret_g, 2'b00};
      default:       tgt = 4'b0000;
    endcase
  end

  assign off_m = grp & ~tgt;
  assign on_m  = tgt & ~grp;

  always_comb begin
    hi_i = 2'd0;
    for (int k = 0; k < NGRP; k++) if (off_m[k]) hi_i = 2'(k);
    lo_i = 2'd0;
    for (int k = NGRP - 1; k >= 0; k--) if (on_m[k]) lo_i = 2'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp <= '0;
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (off_m != '0) begin
      grp[hi_i] <= 1'b0;
      cnt       <= step_gap;
    end else if (on_m != '0) begin
      grp[lo_i] <= 1'b1;
      cnt       <= step_gap;
    end
  end

  assign seq_done   = (grp == tgt) && (cnt == '0);
  assign hw_handoff = (ph == P_HAND);
  assign mcu_en     = {MCU_RAILS{grp[0]}};
  assign main_en    = {MAIN_RAILS{grp[1]}};
  assign gpio_en    = {GPIO_RAILS{grp[2]}};
  assign ddr_en     = {DDR_RAILS{grp[3]}};
  assign drv_out    = drv_bit & supply_ok &
                      (ph == P_ACT || ph == P_MCU || ph == P_SERR);

  always_comb begin
    unique case (ph)
      P_ACT:   mode = 3'd1;
      P_MCU:   mode = 3'd2;
      P_SERR:  mode = 3'd3;
      P_RET:   mode = 3'd4;
      default: mode = 3'd0;
    endcase
  end

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic       hard_fault,
  input logic       soc_clear,
  input logic [2:0] mode,
  input logic       drv_out,
  input logic       drv_bit,
  input logic       seq_done,
  input logic       hw_handoff,
  input logic       init_done,
  input logic       buck_rv_off,
  input logic       ldo_rv_off,
  input logic       first_boot_done,
  input logic [1:0] vsup_mask,
  input logic [0:0] mcu_en,
  input logic [0:0] main_en,
  input logic [0:0] gpio_en,
  input logic [0:0] ddr_en
);
  logic [3:0] g;
  assign g = {ddr_en[0], gpio_en[0], main_en[0], mcu_en[0]};

  // R3
  stby_drv_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd0 |-> !drv_out);

  // R9
  one_group_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(g ^ $past(g)));

  // R4
  active_all_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && seq_done) |-> (g == 4'b1111 && drv_bit));

  // R5
  mcu_island_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd2 || mode == 3'd3) && seq_done) |-> g == 4'b0001);

  // R6
  serr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !soc_clear && !hard_fault && supply_ok) |=> mode == 3'd3);

  // R7
  ret_drv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd4 |-> !drv_bit);

  // R8
  handoff_rails_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_handoff |-> (g == 4'b0000 && mode == 3'd0));

  // R1
  init_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (buck_rv_off && ldo_rv_off && first_boot_done && vsup_mask == 2'b00));
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hard_fault(hard_fault),
  .soc_clear(soc_clear), .mode(mode), .drv_out(drv_out), .drv_bit(drv_bit),
  .seq_done(seq_done), .hw_handoff(hw_handoff), .init_done(init_done),
  .buck_rv_off(buck_rv_off), .ldo_rv_off(ldo_rv_off),
  .first_boot_done(first_boot_done), .vsup_mask(vsup_mask),
  .mcu_en(mcu_en[0]), .main_en(main_en[0]), .gpio_en(gpio_en[0]), .ddr_en(ddr_en[0])
);

// File: tb/sim_pwr_state_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctrl;
  logic clk = 0, rst_n = 0;
  logic supply_ok = 1, on_req = 0, go_mcu = 0, go_ret = 0;
  logic soc_fault = 0, soc_clear = 0, hard_fault = 0, hw_ack = 0;
  logic [7:0] ret_cfg = 8'h00;
  logic [7:0] step_gap = 8'd3;
  logic [2:0] mcu_en;
  logic [4:0] main_en;
  logic [1:0] gpio_en, ddr_en;
  logic drv_out, drv_bit, init_done, seq_done, hw_handoff;
  logic buck_rv_off, ldo_rv_off, first_boot_done;
  logic [1:0] vsup_mask;
  logic [2:0] mode;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  pwr_state_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .on_req(on_req),
    .go_mcu(go_mcu), .go_ret(go_ret), .soc_fault(soc_fault), .soc_clear(soc_clear),
    .hard_fault(hard_fault), .ret_cfg(ret_cfg), .step_gap(step_gap), .hw_ack(hw_ack),
    .mcu_en(mcu_en), .main_en(main_en), .gpio_en(gpio_en), .ddr_en(ddr_en),
    .drv_out(drv_out), .drv_bit(drv_bit), .mode(mode), .init_done(init_done),
    .seq_done(seq_done), .hw_handoff(hw_handoff), .buck_rv_off(buck_rv_off),
    .ldo_rv_off(ldo_rv_off), .first_boot_done(first_boot_done), .vsup_mask(vsup_mask)
  );

  function automatic logic [3:0] grp();
    return {ddr_en[0], gpio_en[0], main_en[0], mcu_en[0]};
  endfunction

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic done_sim();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // {clr,soc,ret,mcu,on}, {b7,b5}, mode, {ddr,gpio,main,mcu}, drv_bit
  localparam logic [14:0] VT [24] = '{
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1},
    {5'b00010, 2'b00, 3'd2, 4'b0001, 1'b1},
    {5'b10000, 2'b00, 3'd2, 4'b0001, 1'b1},
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1},
    {5'b01000, 2'b00, 3'd3, 4'b0001, 1'b1},
    {5'b00001, 2'b00, 3'd3, 4'b0001, 1'b1},
    {5'b00100, 2'b01, 3'd3, 4'b0001, 1'b1},
    {5'b00010, 2'b00, 3'd3, 4'b0001, 1'b1},
    {5'b10000, 2'b00, 3'd2, 4'b0001, 1'b1},
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1},
    {5'b00100, 2'b01, 3'd4, 4'b0100, 1'b0},
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1},
    {5'b00100, 2'b10, 3'd4, 4'b1000, 1'b0},
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1},
    {5'b00100, 2'b11, 3'd4, 4'b1100, 1'b0},
    {5'b00010, 2'b00, 3'd2, 4'b0001, 1'b0},
    {5'b00100, 2'b00, 3'd4, 4'b0000, 1'b0},
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1},
    {5'b00111, 2'b01, 3'd4, 4'b0100, 1'b0},
    {5'b00011, 2'b00, 3'd2, 4'b0001, 1'b0},
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1},
    {5'b01110, 2'b00, 3'd3, 4'b0001, 1'b1},
    {5'b10000, 2'b00, 3'd2, 4'b0001, 1'b1},
    {5'b00001, 2'b00, 3'd1, 4'b1111, 1'b1}
  };

  task automatic pulse_ack();
    @(negedge clk) hw_ack = 1;
    @(posedge clk) #1 hw_ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    done_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mask", vsup_mask, 3);
    chk("R1 reset buck", buck_rv_off, 0);
    chk("R11 reset mode", mode, 0);
    chk("R3 reset rails", grp(), 0);
    rst_n = 1;
    on_req = 1;
    @(posedge clk) #1;
    chk("R1 step1 buck", buck_rv_off, 1); chk("R1 step1 ldo", ldo_rv_off, 0);
    @(posedge clk) #1;
    chk("R1 step2 ldo", ldo_rv_off, 1); chk("R1 step2 first", first_boot_done, 0);
    @(posedge clk) #1;
    chk("R1 step3 first", first_boot_done, 1); chk("R1 step3 mask", vsup_mask, 3);
    on_req = 0;
    @(posedge clk) #1;
    chk("R1 step4 mask", vsup_mask, 0); chk("R1 step4 done", init_done, 1);
    repeat (5) @(negedge clk);
    chk("R2 on during init ignored", mode, 0);

    supply_ok = 0;
    @(negedge clk) on_req = 1;
    @(negedge clk) on_req = 0;
    repeat (5) @(negedge clk);
    chk("R2 on without supply", mode, 0);
    chk("R3 standby drv pin", drv_out, 0);
    chk("R3 standby rails", grp(), 0);
    supply_ok = 1;

    // R9 exact step timing with step_gap = 3
    @(negedge clk) on_req = 1;
    @(posedge clk) #1 on_req = 0;
    chk("R11 active code", mode, 1);
    chk("R4 drv pin", drv_out, 1);
    @(posedge clk) #1 chk("R9 mcu first", grp(), 4'b0001);
    repeat (3) @(posedge clk); #1 chk("R9 gap hold", grp(), 4'b0001);
    @(posedge clk) #1 chk("R9 main second", grp(), 4'b0011);
    repeat (4) @(posedge clk); #1 chk("R9 gpio third", grp(), 4'b0111);
    repeat (4) @(posedge clk); #1 chk("R9 ddr fourth", grp(), 4'b1111);
    chk("R9 not done yet", seq_done, 0);
    repeat (2) @(posedge clk); #1 chk("R9 still waiting", seq_done, 0);
    @(posedge clk) #1 chk("R9 done", seq_done, 1);

    for (int i = 0; i < 24; i++) begin
      automatic logic [14:0] v = VT[i];
      @(negedge clk);
      {soc_clear, soc_fault, go_ret, go_mcu, on_req} = v[14:10];
      ret_cfg = {v[9], 1'b0, v[8], 5'b0};
      @(negedge clk);
      {soc_clear, soc_fault, go_ret, go_mcu, on_req} = 5'b0;
      ret_cfg = 8'h00;
      repeat (40) @(negedge clk);
      chk($sformatf("R11 R10 R6 vec%0d mode", i), mode, v[7:5]);
      chk($sformatf("R4 R5 R7 vec%0d rails", i), grp(), v[4:1]);
      chk($sformatf("R4 R7 vec%0d drv_bit", i), drv_bit, v[0]);
      chk($sformatf("R9 vec%0d seq_done", i), seq_done, 1);
    end

    // R7 select bits taken only at the trigger
    @(negedge clk) begin go_ret = 1; ret_cfg = 8'h20; end
    @(negedge clk) begin go_ret = 0; ret_cfg = 8'hA0; end
    repeat (40) @(negedge clk);
    chk("R7 late cfg ignored", grp(), 4'b0100);
    ret_cfg = 8'h00;
    @(negedge clk) on_req = 1;
    @(negedge clk) on_req = 0;
    repeat (40) @(negedge clk);

    // R8 hard fault from active
    @(negedge clk) hard_fault = 1;
    @(posedge clk) #1 hard_fault = 0;
    chk("R8 fault mode", mode, 0);
    chk("R8 fault drv", drv_bit, 0);
    @(posedge clk) #1;
    chk("R9 ddr off first", grp(), 4'b0111);
    chk("R8 no early handoff", hw_handoff, 0);
    repeat (40) @(negedge clk);
    chk("R8 rails off", grp(), 0);
    chk("R8 handoff", hw_handoff, 1);
    pulse_ack();
    chk("R8 handoff drop", hw_handoff, 0);
    chk("R1 rerun mask", vsup_mask, 3);
    chk("R1 rerun buck", buck_rv_off, 0);
    repeat (10) @(negedge clk);
    chk("R1 rerun done", init_done, 1);
    chk("R3 back in standby", mode, 0);

    // R8 supply loss from MCU-only
    @(negedge clk) go_mcu = 1;
    @(negedge clk) go_mcu = 0;
    repeat (30) @(negedge clk);
    chk("R5 mcu from standby", grp(), 4'b0001);
    supply_ok = 0;
    repeat (40) @(negedge clk);
    chk("R8 supply loss handoff", hw_handoff, 1);
    chk("R8 supply loss rails", grp(), 0);
    supply_ok = 1;
    pulse_ack();
    repeat (10) @(negedge clk);

    // R10 fault wins over everything
    @(negedge clk) on_req = 1;
    @(negedge clk) on_req = 0;
    repeat (40) @(negedge clk);
    @(negedge clk) {hard_fault, soc_fault, go_ret, go_mcu, on_req} = 5'b11111;
    @(posedge clk) #1 {hard_fault, soc_fault, go_ret, go_mcu, on_req} = 5'b0;
    chk("R10 fault first", mode, 0);
    repeat (40) @(negedge clk);
    chk("R10 fault reaches handoff", hw_handoff, 1);
    pulse_ack();
    repeat (10) @(negedge clk);
    chk("R2 standby after recovery", mode, 0);
    done_sim();
  end
endmodule